// File: doc/BRIEF.md
# Priority Interrupt Sequence Controller

This block gives a small 18-bit stored-program processor sixteen prioritised break channels. Each channel catches requests from devices or external lines as rising edges. A channel can also be forced to break by software. When the processor reports that its current memory cycle has finished, the block decides whether to break into the running program. If it does, it stalls the processor and writes three words of context into memory slots reserved for the winning channel: the accumulator, the program counter word and the IO register. It then hands the processor a new program counter.

Each channel n owns four consecutive memory words starting at address 4n. Word 4n+3 is the service entry point. Breaks nest strictly by priority, and channel 0 has the highest priority. The interrupted program resumes when it performs an indirect jump through word 4n+1. The block sees that jump on its return port. It frees channel n and passes the saved program counter and overflow flag back to the processor. Control commands mask and unmask single channels, flush all pending requests, force a break, and arm or disarm the whole break system.

The sequencer has five states: IDLE, SAVE_AC, SAVE_PC, SAVE_IO and VECTOR. It has these transitions:
- IDLE to SAVE_AC when a break is taken.
- SAVE_AC to SAVE_PC, SAVE_PC to SAVE_IO, and SAVE_IO to VECTOR, each on a memory grant.
- VECTOR to IDLE unconditionally.
- Each SAVE state stays where it is while the grant is low.

Top module: `brk_ctrl`

## Requirements
- R1: After reset, the block is in IDLE: `busy_o`, `mem_req_o` and `pc_load_o` are low, `active_o` is zero, every channel is masked, the system is disarmed and nothing is pending.
- R2: A 0-to-1 transition on `req_i[n]` sets channel n pending. A level held high does not set it again. A pending request stays latched while its channel is masked, while the system is disarmed, or while it is blocked by a channel of equal or higher priority that is in service. It is serviced once none of these holds.
- R3: A break is taken only when all of these hold: the block is in IDLE, the system is armed, and `cyc_end_i` is high at that clock edge. `busy_o` and the new `active_o` bit appear one cycle later.
- R4: The three save states each raise `mem_req_o` and hold the address and data steady until `mem_gnt_i` is high. They write, in this order:
  - the accumulator to address 4n;
  - the program counter word to address 4n+1, with the overflow flag in bit 17, the program counter in bits 11:0 and zeros in bits 16:12;
  - the IO register to address 4n+2.
  The written values are those present at the `cpu_*` inputs in the cycle the break was taken.
- R5: The cycle after the third write is granted, the block is in VECTOR: `pc_load_o` is high for one cycle with `pc_val_o` = 4n+3. The block then returns to IDLE.
- R6: Among the eligible channels, the lowest-numbered one wins.
- R7: A channel is eligible only when its number is lower than that of every channel in service.
- R8: While `busy_o` is high, no further channel enters service.
- R9: Commands are applied at the clock edge where `cmd_valid_i` is high. The codes on `cmd_op_i` are: 1 masks channel `cmd_chan_i`, 2 unmasks it, 5 arms the system and 6 disarms it. Codes 0 and 7 do nothing. A masked channel's device requests never start a break.
- R10: Code 4 forces a break request on channel `cmd_chan_i`. The request is taken even when that channel is masked, subject to arming and priority.
- R11: A `ret_valid_i` whose address is 4n+1 with n < 16 clears `active_o[n]` at the next edge. In the same cycle it drives `pc_load_o` high, `pc_val_o` from `ret_word_i[11:0]`, and `ovf_load_o` high with `ovf_val_o` = `ret_word_i[17]`. A return to any other address has no effect.
- R12: Code 3 flushes every pending request, both device and forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Per-channel request lines, edge-captured |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_chan_i | input | 4 | Channel the command addresses |
| cyc_end_i | input | 1 | Processor's current memory cycle has completed |
| cpu_ac_i | input | 18 | Processor accumulator |
| cpu_pc_i | input | 12 | Processor program counter |
| cpu_io_i | input | 18 | Processor IO register |
| cpu_ovf_i | input | 1 | Processor overflow flag |
| mem_gnt_i | input | 1 | Memory grant for the current write |
| ret_valid_i | input | 1 | Processor performed an indirect jump |
| ret_addr_i | input | 12 | Address the indirect jump went through |
| ret_word_i | input | 18 | Word read from that address |
| busy_o | output | 1 | Break sequence in progress; the processor stalls |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 12 | Memory write address |
| mem_wdata_o | output | 18 | Memory write data |
| pc_load_o | output | 1 | Load `pc_val_o` into the program counter |
| pc_val_o | output | 12 | New program counter |
| ovf_load_o | output | 1 | Load `ovf_val_o` into the overflow flag |
| ovf_val_o | output | 1 | Restored overflow flag |
| active_o | output | 16 | Channels currently in service |

## Verification
A lost or doubled in-service bit shows on `active_o` at the very next edge. It then shows as a wrong preemption decision the next time a request arrives. A stale snapshot or a wrong channel index shows up during the save itself: the address or data on the memory port is wrong in that same cycle. A pending bit that is cleared when it should be held, or held when it should be cleared, only shows when the channel next becomes eligible. For that reason the reference model is compared on every clock rather than only at the end of each scenario.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_MASK    = 3'd1,
        OP_UNMASK  = 3'd2,
        OP_FLUSH   = 3'd3,
        OP_FORCE   = 3'd4,
        OP_ARM     = 3'd5,
        OP_DISARM  = 3'd6
    } brk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE_AC  = 3'd1,
        ST_SAVE_PC  = 3'd2,
        ST_SAVE_IO  = 3'd3,
        ST_VECTOR   = 3'd4
    } brk_state_e;

    localparam logic [1:0] SLOT_AC  = 2'd0;
    localparam logic [1:0] SLOT_PC  = 2'd1;
    localparam logic [1:0] SLOT_IO  = 2'd2;
    localparam logic [1:0] SLOT_ENT = 2'd3;

endpackage

// File: rtl/brk_pending.sv
`timescale 1ns/1ps
module brk_pending
    import brk_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            req_i,
    input  logic                      cmd_valid_i,
    input  logic [2:0]                cmd_op_i,
    input  logic [$clog2(NCH)-1:0]    cmd_chan_i,
    input  logic                      take_i,
    input  logic [$clog2(NCH)-1:0]    take_ch_i,
    output logic [NCH-1:0]            cand_o,
    output logic                      armed_o
);
    localparam int CH_W = $clog2(NCH);

    brk_op_e        op;
    logic           is_flush;
    logic [NCH-1:0] req_q;
    logic [NCH-1:0] rise;

    assign op       = brk_op_e'(cmd_op_i);
    assign is_flush = cmd_valid_i && (op == OP_FLUSH);
    assign rise     = req_i & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
        end else if (cmd_valid_i && op == OP_ARM) begin
            armed_o <= 1'b1;
        end else if (cmd_valid_i && op == OP_DISARM) begin
            armed_o <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hw_q;
        logic sw_q;
        logic en_q;
        logic addressed;
        logic taken;

        assign addressed = cmd_valid_i && (cmd_chan_i == CH_W'(g));
        assign taken     = take_i && (take_ch_i == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hw_q <= 1'b0;
            end else if (taken || is_flush) begin
                hw_q <= 1'b0;
            end else if (rise[g]) begin
                hw_q <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sw_q <= 1'b0;
            end else if (taken || is_flush) begin
                sw_q <= 1'b0;
            end else if (addressed && op == OP_FORCE) begin
                sw_q <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else if (addressed && op == OP_MASK) begin
                en_q <= 1'b0;
            end else if (addressed && op == OP_UNMASK) begin
                en_q <= 1'b1;
            end
        end

        assign cand_o[g] = (hw_q && en_q) || sw_q;
    end

endmodule

// File: rtl/brk_arbiter.sv
`timescale 1ns/1ps
module brk_arbiter #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0]            cand_i,
    input  logic [NCH-1:0]            isv_i,
    output logic                      hit_o,
    output logic [$clog2(NCH)-1:0]    ch_o
);
    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0] elig;

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            blocked = blocked | isv_i[i];
            elig[i] = cand_i[i] & ~blocked;
        end
    end

    always_comb begin
        hit_o = |elig;
        ch_o  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                ch_o = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/brk_sequencer.sv
`timescale 1ns/1ps
module brk_sequencer
    import brk_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int WORD_W = 18,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit_i,
    input  logic [$clog2(NCH)-1:0]    hit_ch_i,
    input  logic                      armed_i,
    input  logic                      cyc_end_i,
    input  logic [WORD_W-1:0]         cpu_ac_i,
    input  logic [ADDR_W-1:0]         cpu_pc_i,
    input  logic [WORD_W-1:0]         cpu_io_i,
    input  logic                      cpu_ovf_i,
    input  logic                      mem_gnt_i,
    input  logic                      ret_valid_i,
    input  logic [ADDR_W-1:0]         ret_addr_i,
    input  logic [WORD_W-1:0]         ret_word_i,
    output logic                      take_o,
    output logic [NCH-1:0]            isv_o,
    output logic                      busy_o,
    output logic                      mem_req_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [WORD_W-1:0]         mem_wdata_o,
    output logic                      pc_load_o,
    output logic [ADDR_W-1:0]         pc_val_o,
    output logic                      ovf_load_o,
    output logic                      ovf_val_o
);
    localparam int CH_W = $clog2(NCH);

    brk_state_e        state_q, state_n;
    logic [CH_W-1:0]   ch_q;
    logic [WORD_W-1:0] ac_q, pcw_q, io_q, pcw_now;
    logic [NCH-1:0]    isv_q, isv_n;
    logic              ret_hit;
    logic [CH_W-1:0]   ret_ch;
    logic [1:0]        slot;
    logic              vec;
    logic              unused_bits;

    assign unused_bits = ^ret_word_i[WORD_W-2:ADDR_W];

    assign take_o  = (state_q == ST_IDLE) && hit_i && armed_i && cyc_end_i;
    assign ret_ch  = ret_addr_i[CH_W+1:2];
    assign ret_hit = ret_valid_i && (ret_addr_i[1:0] == SLOT_PC)
                     && ((ret_addr_i >> (CH_W + 2)) == '0);

    always_comb begin
        pcw_now               = '0;
        pcw_now[ADDR_W-1:0]   = cpu_pc_i;
        pcw_now[WORD_W-1]     = cpu_ovf_i;
    end

    always_comb begin
        isv_n = isv_q;
        if (ret_hit) begin
            isv_n[ret_ch] = 1'b0;
        end
        if (take_o) begin
            isv_n[hit_ch_i] = 1'b1;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_o)    state_n = ST_SAVE_AC;
            ST_SAVE_AC: if (mem_gnt_i) state_n = ST_SAVE_PC;
            ST_SAVE_PC: if (mem_gnt_i) state_n = ST_SAVE_IO;
            ST_SAVE_IO: if (mem_gnt_i) state_n = ST_VECTOR;
            ST_VECTOR:                 state_n = ST_IDLE;
            default:                   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            ac_q    <= '0;
            pcw_q   <= '0;
            io_q    <= '0;
            isv_q   <= '0;
        end else begin
            state_q <= state_n;
            isv_q   <= isv_n;
            if (take_o) begin
                ch_q  <= hit_ch_i;
                ac_q  <= cpu_ac_i;
                pcw_q <= pcw_now;
                io_q  <= cpu_io_i;
            end
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_wdata_o = '0;
        slot        = SLOT_AC;
        vec         = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SAVE_AC: begin
                mem_req_o   = 1'b1;
                slot        = SLOT_AC;
                mem_wdata_o = ac_q;
            end
            ST_SAVE_PC: begin
                mem_req_o   = 1'b1;
                slot        = SLOT_PC;
                mem_wdata_o = pcw_q;
            end
            ST_SAVE_IO: begin
                mem_req_o   = 1'b1;
                slot        = SLOT_IO;
                mem_wdata_o = io_q;
            end
            ST_VECTOR: vec = 1'b1;
            default: ;
        endcase
        busy_o     = (state_q != ST_IDLE);
        mem_addr_o = ADDR_W'({ch_q, slot});
        pc_load_o  = vec || ret_hit;
        pc_val_o   = vec ? ADDR_W'({ch_q, SLOT_ENT}) : ret_word_i[ADDR_W-1:0];
        ovf_load_o = ret_hit && !vec;
        ovf_val_o  = ret_word_i[WORD_W-1];
    end

    assign isv_o = isv_q;

    // R4
    save_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i && state_q != ST_SAVE_IO)
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

    // R4
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i)
        |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R5
    vector_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE_IO && mem_gnt_i)
        |=> (pc_load_o && pc_val_o[1:0] == SLOT_ENT && !mem_req_o));

    // R8
    no_entry_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($countones(isv_q) <= $countones($past(isv_q))));

endmodule

// File: rtl/brk_ctrl.sv
`timescale 1ns/1ps
module brk_ctrl #(
    parameter int NCH    = 16,
    parameter int WORD_W = 18,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            req_i,
    input  logic                      cmd_valid_i,
    input  logic [2:0]                cmd_op_i,
    input  logic [$clog2(NCH)-1:0]    cmd_chan_i,
    input  logic                      cyc_end_i,
    input  logic [WORD_W-1:0]         cpu_ac_i,
    input  logic [ADDR_W-1:0]         cpu_pc_i,
    input  logic [WORD_W-1:0]         cpu_io_i,
    input  logic                      cpu_ovf_i,
    input  logic                      mem_gnt_i,
    input  logic                      ret_valid_i,
    input  logic [ADDR_W-1:0]         ret_addr_i,
    input  logic [WORD_W-1:0]         ret_word_i,
    output logic                      busy_o,
    output logic                      mem_req_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [WORD_W-1:0]         mem_wdata_o,
    output logic                      pc_load_o,
    output logic [ADDR_W-1:0]         pc_val_o,
    output logic                      ovf_load_o,
    output logic                      ovf_val_o,
    output logic [NCH-1:0]            active_o
);
    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0]  cand;
    logic            armed;
    logic            hit;
    logic [CH_W-1:0] hit_ch;
    logic            take;

    brk_pending #(.NCH(NCH)) u_pending (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_chan_i  (cmd_chan_i),
        .take_i      (take),
        .take_ch_i   (hit_ch),
        .cand_o      (cand),
        .armed_o     (armed)
    );

    brk_arbiter #(.NCH(NCH)) u_arbiter (
        .cand_i (cand),
        .isv_i  (active_o),
        .hit_o  (hit),
        .ch_o   (hit_ch)
    );

    brk_sequencer #(.NCH(NCH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .hit_ch_i    (hit_ch),
        .armed_i     (armed),
        .cyc_end_i   (cyc_end_i),
        .cpu_ac_i    (cpu_ac_i),
        .cpu_pc_i    (cpu_pc_i),
        .cpu_io_i    (cpu_io_i),
        .cpu_ovf_i   (cpu_ovf_i),
        .mem_gnt_i   (mem_gnt_i),
        .ret_valid_i (ret_valid_i),
        .ret_addr_i  (ret_addr_i),
        .ret_word_i  (ret_word_i),
        .take_o      (take),
        .isv_o       (active_o),
        .busy_o      (busy_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .pc_load_o   (pc_load_o),
        .pc_val_o    (pc_val_o),
        .ovf_load_o  (ovf_load_o),
        .ovf_val_o   (ovf_val_o)
    );

    // R3
    start_on_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cyc_end_i));

    // R7
    entry_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |->
            ($countones(active_o & ~$past(active_o)) == 1 &&
             (((active_o & ~$past(active_o)) - 1'b1) & active_o) == '0));

endmodule

// File: tb/brk_ctrl_tb.sv
`timescale 1ns/1ps
module brk_ctrl_tb;
    localparam int NCH = 16;
    localparam int AW  = 12;
    localparam int WW  = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] req_i = '0;
    logic cmd_valid_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [3:0] cmd_chan_i = '0;
    logic cyc_end_i = 1'b1;
    logic [WW-1:0] cpu_ac_i = 18'o123456;
    logic [AW-1:0] cpu_pc_i = 12'o4321;
    logic [WW-1:0] cpu_io_i = 18'o654321;
    logic cpu_ovf_i = 1'b1;
    logic mem_gnt_i = 1'b1;
    logic ret_valid_i = 1'b0;
    logic [AW-1:0] ret_addr_i = '0;
    logic [WW-1:0] ret_word_i = '0;
    logic busy_o, mem_req_o, pc_load_o, ovf_load_o, ovf_val_o;
    logic [AW-1:0] mem_addr_o, pc_val_o;
    logic [WW-1:0] mem_wdata_o;
    logic [NCH-1:0] active_o;

    brk_ctrl u_dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_reqq, m_hw, m_sw, m_en, m_isv;
    bit m_glb;
    int m_st, m_ch;
    logic [17:0] m_ac, m_pcw, m_io;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reqq = '0; m_hw = '0; m_sw = '0; m_en = '0; m_isv = '0;
            m_glb = 0; m_st = 0; m_ch = 0; m_ac = '0; m_pcw = '0; m_io = '0;
        end else begin
            logic [15:0] rise, cand;
            int sel, blk, c;
            bit take, rh;
            rise = req_i & ~m_reqq;
            m_reqq = req_i;
            cand = (m_hw & m_en) | m_sw;
            sel = -1; blk = 0;
            for (int i = 0; i < 16; i++) begin
                if (m_isv[i]) blk = 1;
                if (sel < 0 && blk == 0 && cand[i]) sel = i;
            end
            take = (m_st == 0) && (sel >= 0) && m_glb && cyc_end_i;
            rh = ret_valid_i && ret_addr_i[1:0] == 2'd1 && ret_addr_i < 64;
            c = int'(cmd_chan_i);
            m_hw = m_hw | rise;
            if (cmd_valid_i) begin
                case (cmd_op_i)
                    3'd1: m_en[c] = 1'b0;
                    3'd2: m_en[c] = 1'b1;
                    3'd3: begin m_hw = '0; m_sw = '0; end
                    3'd4: m_sw[c] = 1'b1;
                    3'd5: m_glb = 1;
                    3'd6: m_glb = 0;
                    default: ;
                endcase
            end
            if (take) begin m_hw[sel] = 1'b0; m_sw[sel] = 1'b0; end
            if (rh) m_isv[int'(ret_addr_i) / 4] = 1'b0;
            if (take) m_isv[sel] = 1'b1;
            case (m_st)
                0: if (take) begin
                       m_st = 1; m_ch = sel; m_ac = cpu_ac_i; m_io = cpu_io_i;
                       m_pcw = {cpu_ovf_i, 5'b0, cpu_pc_i};
                   end
                1, 2, 3: if (mem_gnt_i) m_st = m_st + 1;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit rh;
            rh = ret_valid_i && ret_addr_i[1:0] == 2'd1 && ret_addr_i < 64;
            chk("R3 busy", 32'(busy_o), 32'(m_st != 0));
            chk("R4 mem_req", 32'(mem_req_o), 32'(m_st >= 1 && m_st <= 3));
            if (m_st >= 1 && m_st <= 3) begin
                chk("R4 addr", 32'(mem_addr_o), 32'(m_ch * 4 + m_st - 1));
                chk("R4 data", 32'(mem_wdata_o),
                    32'(m_st == 1 ? m_ac : (m_st == 2 ? m_pcw : m_io)));
            end
            chk("R5 pc_load", 32'(pc_load_o), 32'(m_st == 4 || rh));
            if (m_st == 4) chk("R5 pc_val", 32'(pc_val_o), 32'(m_ch * 4 + 3));
            else if (rh) chk("R11 pc_val", 32'(pc_val_o), 32'(ret_word_i[11:0]));
            chk("R11 ovf_load", 32'(ovf_load_o), 32'(rh && m_st != 4));
            if (rh && m_st != 4) chk("R11 ovf_val", 32'(ovf_val_o), 32'(ret_word_i[17]));
            chk("R7 active", 32'(active_o), 32'(m_isv));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        tick(10);
    endtask

    task automatic do_cmd(input logic [2:0] op, input int ch);
        cmd_valid_i = 1'b1; cmd_op_i = op; cmd_chan_i = 4'(ch);
        tick(1);
        cmd_valid_i = 1'b0; cmd_op_i = '0;
    endtask

    task automatic pulse(input int ch);
        req_i[ch] = 1'b1;
        tick(1);
        req_i[ch] = 1'b0;
    endtask

    task automatic do_ret(input int addr, input logic [17:0] w);
        ret_valid_i = 1'b1; ret_addr_i = 12'(addr); ret_word_i = w;
        tick(1);
        ret_valid_i = 1'b0;
    endtask

    task automatic look_active(input string tag, input logic [15:0] exp);
        @(negedge clk);
        chk(tag, 32'(active_o), 32'(exp));
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        @(negedge clk);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 mem_req", 32'(mem_req_o), 0);
        chk("R1 pc_load", 32'(pc_load_o), 0);
        chk("R1 active", 32'(active_o), 0);
        tick(1);

        // R2: latched while masked, serviced once unmasked
        pulse(1);
        do_cmd(3'd5, 0);
        settle();
        look_active("R2 masked hold", 16'h0000);
        do_cmd(3'd2, 1);
        settle();
        look_active("R2 serviced", 16'h0002);

        // R11: return through word 5
        ret_valid_i = 1'b1; ret_addr_i = 12'd5; ret_word_i = 18'h20123;
        @(negedge clk);
        chk("R11 pc_load", 32'(pc_load_o), 1);
        chk("R11 pc_val", 32'(pc_val_o), 32'h123);
        chk("R11 ovf_load", 32'(ovf_load_o), 1);
        chk("R11 ovf_val", 32'(ovf_val_o), 1);
        tick(1);
        ret_valid_i = 1'b0;
        look_active("R11 freed", 16'h0000);

        // R4/R5: save sequence on channel 5
        do_cmd(3'd2, 5);
        pulse(5);
        tick(3);
        @(negedge clk);
        chk("R4 io slot", 32'(mem_addr_o), 32'd22);
        tick(1);
        @(negedge clk);
        chk("R5 vector", 32'(pc_val_o), 32'd23);
        chk("R5 load", 32'(pc_load_o), 1);
        settle();
        look_active("R6 ch5", 16'h0020);

        // R7: lower priority blocked, higher preempts with stalled grant
        do_cmd(3'd2, 9);
        pulse(9);
        settle();
        look_active("R7 blocked", 16'h0020);
        do_cmd(3'd2, 0);
        do_cmd(3'd2, 2);
        mem_gnt_i = 1'b0;
        pulse(2);
        tick(4);
        @(negedge clk);
        chk("R4 stall busy", 32'(busy_o), 1);
        chk("R4 stall addr", 32'(mem_addr_o), 32'd8);
        chk("R4 stall data", 32'(mem_wdata_o), 32'(cpu_ac_i));
        tick(1);
        pulse(0);
        tick(3);
        look_active("R8 no entry", 16'h0024);
        mem_gnt_i = 1'b1;
        settle();
        settle();
        look_active("R7 nested", 16'h0025);

        do_ret(1, '0);
        look_active("R11 ch0 free", 16'h0024);
        do_ret(8, '0);
        look_active("R11 ignored", 16'h0024);
        do_ret(9, '0);
        settle();
        look_active("R7 ch9 waits", 16'h0020);
        do_ret(21, '0);
        settle();
        look_active("R2 ch9 later", 16'h0200);
        do_ret(37, '0);
        settle();

        // R9/R10: masked ignored, forced taken
        pulse(3);
        settle();
        look_active("R9 masked", 16'h0000);
        do_cmd(3'd4, 3);
        settle();
        look_active("R10 forced", 16'h0008);
        do_ret(13, '0);
        settle();

        // R6: simultaneous requests
        do_cmd(3'd2, 7);
        do_cmd(3'd2, 4);
        req_i[7] = 1'b1; req_i[4] = 1'b1;
        tick(1);
        req_i = '0;
        settle();
        look_active("R6 lowest", 16'h0010);
        do_ret(17, '0);
        settle();
        look_active("R6 next", 16'h0080);
        do_ret(29, '0);
        settle();

        // R3: wait for cycle end
        do_cmd(3'd2, 6);
        cyc_end_i = 1'b0;
        pulse(6);
        tick(5);
        @(negedge clk);
        chk("R3 no start", 32'(busy_o), 0);
        tick(1);
        cyc_end_i = 1'b1;
        tick(1);
        @(negedge clk);
        chk("R3 start", 32'(busy_o), 1);
        settle();
        do_ret(25, '0);
        settle();

        // R9: disarmed keeps pending
        do_cmd(3'd6, 0);
        pulse(6);
        settle();
        look_active("R9 disarmed", 16'h0000);
        do_cmd(3'd5, 0);
        settle();
        look_active("R2 rearmed", 16'h0040);
        do_ret(25, '0);
        settle();

        // R12: flush
        do_cmd(3'd1, 6);
        pulse(6);
        settle();
        do_cmd(3'd3, 0);
        do_cmd(3'd2, 6);
        settle();
        look_active("R12 flushed", 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule